// File: doc/BRIEF.md
# Half-Bridge Gate Drive Sequencer

This block turns a single PWM command into two gate enables for the upper and lower switches of a synchronous buck half-bridge. It never switches one gate on until the other is off. Each gate waits for a digitized flag reporting that the opposite gate voltage has dropped below its turn-on threshold. Because of this, the dead time follows the real discharge of each gate rather than a fixed count.

The PWM level arrives already classified by comparators as low, high or mid-window. It passes through a two-flop synchronizer before it is used. A mid-window level that persists for a holdoff period shuts both gates off. The shutdown lasts only while the level stays in the window. When the forced-continuous select is low, the block emulates a diode. Once the lower gate has been on for a minimum time, a zero-current flag removes it until the next high PWM period. Raising the select brings continuous conduction back without waiting for a PWM edge. A supply-good input holds everything off while it is low.

Top module: `hb_gate_seq`

## Requirements
- R1: After the PWM code goes to high (01), the lower enable drops 3 clock edges later. The upper enable rises only on the edge after a cycle in which `lo_gate_dis` is 1, and stays low while `lo_gate_dis` is 0.
- R2: After the PWM code goes to low (00), the upper enable drops 3 edges later. The lower enable rises only on the edge after a cycle in which `hi_gate_dis` is 1, and stays low while `hi_gate_dis` is 0.
- R3: `hi_en` and `lo_en` are never 1 in the same cycle.
- R4: The mid-window code (10), held continuously, leaves the gate enables unchanged for HOLDOFF_NS/CLK_NS + 2 edges. After one more edge both enables are 0 and `seq_state` reads 5.
- R5: The unused code 11 behaves exactly as the mid-window code.
- R6: Once shut down, a code of high or low restarts the normal sequence. With the matching discharge flag at 1, the corresponding enable rises 4 edges after the code changes.
- R7: The holdoff count restarts from zero whenever the synchronized code leaves the window, even for a single cycle.
- R8: With `ccm_force` at 1, `zero_cross` has no effect: the lower enable stays on for as long as PWM stays low.
- R9: With `ccm_force` at 0, a zero crossing removes the lower enable (`seq_state` 6). The lower enable stays off until the next high code.
- R10: In diode-emulation mode, the lower enable stays on for at least MIN_ON_NS/CLK_NS + 1 consecutive cycles before a zero crossing can remove it.
- R11: If `ccm_force` rises while the lower gate is cut off by a zero crossing and PWM is low, the lower enable returns 2 edges later (given `hi_gate_dis` at 1). No PWM edge is needed.
- R12: While `rst` is 1, or on the edge after `supply_ok` is 0, both enables are 0 and `seq_state` is 0 (idle). They stay so while `supply_ok` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Bias supply good; 0 forces idle |
| pwm_code | input | 2 | Classified PWM level: 00 low, 01 high, 10/11 mid-window |
| lo_gate_dis | input | 1 | Lower gate voltage below turn-on threshold |
| hi_gate_dis | input | 1 | Upper gate-to-phase voltage below turn-on threshold |
| zero_cross | input | 1 | Inductor current has reached zero |
| ccm_force | input | 1 | 1 forces continuous conduction, 0 allows diode emulation |
| hi_en | output | 1 | Upper gate enable (registered) |
| lo_en | output | 1 | Lower gate enable (registered) |
| seq_state | output | 3 | 0 idle, 1 wait lower off, 2 upper on, 3 wait upper off, 4 lower on, 5 shutdown, 6 lower cut by zero crossing |

## Verification
The properties treat the discharge flags, the zero-crossing flag and the mode select as already synchronous to `clk`. They relate each gate's rise only to the flag value in the preceding cycle. The stimulus honours this by changing every input on the falling clock edge. It moves the discharge flags by hand, so that a gate still reported charged can be seen to block its partner for several cycles. The minimum on-time is judged by counting cycles of the lower enable up to the cycle in which the state reports a zero-crossing cutoff.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_HI_WAIT = 3'd1,
    ST_HI_ON   = 3'd2,
    ST_LO_WAIT = 3'd3,
    ST_LO_ON   = 3'd4,
    ST_SHUT    = 3'd5,
    ST_DCM_OFF = 3'd6
  } seq_st_e;

  localparam logic [1:0] CODE_LO  = 2'b00;
  localparam logic [1:0] CODE_HI  = 2'b01;
  localparam logic [1:0] CODE_MID = 2'b10;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RST_VAL;
      q    <= RST_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/hb_win_timer.sv
// Saturating run-length counter: counts consecutive cycles of 'run',
// clears when 'run' drops, flags when LIMIT cycles have been seen.
module hb_win_timer #(
  parameter int LIMIT = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic reached
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign reached = run && (cnt == LIM);
endmodule

// File: rtl/hb_gate_seq.sv
module hb_gate_seq #(
  parameter int CLK_NS     = 10,
  parameter int HOLDOFF_NS = 160,
  parameter int MIN_ON_NS  = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok,
  input  logic [1:0] pwm_code,
  input  logic       lo_gate_dis,
  input  logic       hi_gate_dis,
  input  logic       zero_cross,
  input  logic       ccm_force,
  output logic       hi_en,
  output logic       lo_en,
  output logic [2:0] seq_state
);
  import hb_pkg::*;

  localparam int HOLD_CYC = HOLDOFF_NS / CLK_NS;
  localparam int MIN_CYC  = MIN_ON_NS / CLK_NS;

  logic [1:0] code_s;
  logic       is_hi, is_lo, is_mid;
  logic       shut_due, min_done;
  seq_st_e    st, nxt;

  hb_sync #(.W(2), .RST_VAL(CODE_MID)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pwm_code),
    .q   (code_s)
  );

  assign is_lo  = (code_s == CODE_LO);
  assign is_hi  = (code_s == CODE_HI);
  assign is_mid = code_s[1];

  hb_win_timer #(.LIMIT(HOLD_CYC)) u_hold (
    .clk     (clk),
    .rst     (rst),
    .run     (is_mid),
    .reached (shut_due)
  );

  hb_win_timer #(.LIMIT(MIN_CYC)) u_min_on (
    .clk     (clk),
    .rst     (rst),
    .run     (st == ST_LO_ON),
    .reached (min_done)
  );

  always_comb begin
    nxt = st;
    unique case (st)
      ST_IDLE, ST_SHUT: begin
        if (is_hi)      nxt = ST_HI_WAIT;
        else if (is_lo) nxt = ST_LO_WAIT;
      end
      ST_HI_WAIT: begin
        if (is_lo)                    nxt = ST_LO_WAIT;
        else if (is_hi && lo_gate_dis) nxt = ST_HI_ON;
      end
      ST_HI_ON: begin
        if (is_lo) nxt = ST_LO_WAIT;
      end
      ST_LO_WAIT: begin
        if (is_hi)                     nxt = ST_HI_WAIT;
        else if (is_lo && hi_gate_dis) nxt = ST_LO_ON;
      end
      ST_LO_ON: begin
        if (is_hi)                                     nxt = ST_HI_WAIT;
        else if (!ccm_force && zero_cross && min_done) nxt = ST_DCM_OFF;
      end
      ST_DCM_OFF: begin
        if (is_hi)                  nxt = ST_HI_WAIT;
        else if (is_lo && ccm_force) nxt = ST_LO_WAIT;
      end
      default: nxt = ST_IDLE;
    endcase
    if (shut_due)   nxt = ST_SHUT;
    if (!supply_ok) nxt = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      hi_en <= 1'b0;
      lo_en <= 1'b0;
    end else begin
      st    <= nxt;
      hi_en <= (nxt == ST_HI_ON);
      lo_en <= (nxt == ST_LO_ON);
    end
  end

  assign seq_state = st;
endmodule

// File: rtl/hb_gate_seq_chk.sv
module hb_gate_seq_chk #(
  parameter int CLK_NS     = 10,
  parameter int HOLDOFF_NS = 160,
  parameter int MIN_ON_NS  = 400
) (
  input logic       clk,
  input logic       rst,
  input logic       supply_ok,
  input logic       lo_gate_dis,
  input logic       hi_gate_dis,
  input logic       ccm_force,
  input logic       hi_en,
  input logic       lo_en,
  input logic [2:0] seq_state
);
  localparam int MIN_CYC = MIN_ON_NS / CLK_NS;
  localparam int RW      = $clog2(MIN_CYC + 3);
  localparam logic [RW-1:0] RMAX = RW'(MIN_CYC + 2);

  logic [RW-1:0] lo_run;

  always_ff @(posedge clk) begin
    if (rst || !lo_en) lo_run <= '0;
    else if (lo_run != RMAX) lo_run <= lo_run + 1'b1;
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(hi_en && lo_en));

  assert_hi_after_lo_off_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_en) |-> ($past(lo_gate_dis) && !$past(lo_en)));

  assert_lo_after_hi_off_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(lo_en) |-> ($past(hi_gate_dis) && !$past(hi_en)));

  assert_supply_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> (!hi_en && !lo_en && seq_state == 3'd0));

  assert_min_on_R10: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd6 && $past(seq_state) == 3'd4) |-> (lo_run >= RW'(MIN_CYC + 1)));

  assert_ccm_no_cut_R8: assert property (@(posedge clk) disable iff (rst)
    (seq_state == 3'd6 && $past(seq_state) != 3'd6) |-> !$past(ccm_force));

  assert_state_range_R12: assert property (@(posedge clk) disable iff (rst)
    seq_state != 3'd7);
endmodule

bind hb_gate_seq hb_gate_seq_chk #(
  .CLK_NS(CLK_NS), .HOLDOFF_NS(HOLDOFF_NS), .MIN_ON_NS(MIN_ON_NS)
) u_chk (
  .clk(clk), .rst(rst), .supply_ok(supply_ok), .lo_gate_dis(lo_gate_dis),
  .hi_gate_dis(hi_gate_dis), .ccm_force(ccm_force), .hi_en(hi_en),
  .lo_en(lo_en), .seq_state(seq_state)
);

// File: tb/hb_gate_seq_tb.sv
module hb_gate_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 160 / 10;
  localparam int MINC = 400 / 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b1;
  logic [1:0] pwm_code = 2'b10;
  logic       lo_gate_dis = 1'b1;
  logic       hi_gate_dis = 1'b1;
  logic       zero_cross = 1'b0;
  logic       ccm_force = 1'b1;
  logic       hi_en, lo_en;
  logic [2:0] seq_state;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hb_gate_seq u_dut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .pwm_code(pwm_code),
    .lo_gate_dis(lo_gate_dis), .hi_gate_dis(hi_gate_dis),
    .zero_cross(zero_cross), .ccm_force(ccm_force),
    .hi_en(hi_en), .lo_en(lo_en), .seq_state(seq_state)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic go_hi_on();
    lo_gate_dis = 1'b1; pwm_code = 2'b01; step(6);
  endtask

  task automatic go_lo_on();
    hi_gate_dis = 1'b1; pwm_code = 2'b00; step(6);
  endtask

  task automatic t_reset();
    step(3);
    check("R12 reset hi_en", hi_en, 0);
    check("R12 reset lo_en", lo_en, 0);
    check("R12 reset state", seq_state, 0);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_rise_R1();
    go_lo_on();
    check("R1 lower on before edge", lo_en, 1);
    lo_gate_dis = 1'b0; pwm_code = 2'b01;
    step(2);
    check("R1 lower still on at edge 2", lo_en, 1);
    step(1);
    check("R1 lower off at edge 3", lo_en, 0);
    step(5);
    check("R1 upper held while lower charged", hi_en, 0);
    lo_gate_dis = 1'b1;
    step(1);
    check("R1 upper on after discharge", hi_en, 1);
  endtask

  task automatic t_fall_R2();
    go_hi_on();
    hi_gate_dis = 1'b0; pwm_code = 2'b00;
    step(3);
    check("R2 upper off at edge 3", hi_en, 0);
    step(5);
    check("R2 lower held while upper charged", lo_en, 0);
    check("R3 both off during wait", int'(hi_en) + int'(lo_en), 0);
    hi_gate_dis = 1'b1;
    step(1);
    check("R2 lower on after discharge", lo_en, 1);
  endtask

  task automatic t_shut_R4_R6(input logic [1:0] code, input string tag);
    go_hi_on();
    pwm_code = code;
    step(HOLD + 2);
    check({tag, " upper kept before holdoff"}, hi_en, 1);
    step(1);
    check({tag, " shut hi_en"}, hi_en, 0);
    check({tag, " shut state"}, seq_state, 5);
    step(10);
    check({tag, " shut held lo_en"}, lo_en, 0);
    lo_gate_dis = 1'b1; pwm_code = 2'b01;
    step(3);
    check("R6 released not yet on", hi_en, 0);
    step(1);
    check("R6 upper back after release", hi_en, 1);
  endtask

  task automatic t_restart_R7();
    go_hi_on();
    pwm_code = 2'b10;
    step(HOLD);
    pwm_code = 2'b01;
    step(1);
    pwm_code = 2'b10;
    step(HOLD + 2);
    check("R7 holdoff restarted", hi_en, 1);
    step(1);
    check("R7 shut after full window", seq_state, 5);
    go_hi_on();
  endtask

  task automatic t_ccm_R8();
    ccm_force = 1'b1; zero_cross = 1'b1;
    go_lo_on();
    step(MINC + 10);
    check("R8 zero cross ignored in ccm", lo_en, 1);
    zero_cross = 1'b0;
  endtask

  task automatic t_dcm_R9_R10_R11();
    go_hi_on();
    ccm_force = 1'b0; zero_cross = 1'b1; hi_gate_dis = 1'b1;
    pwm_code = 2'b00;
    step(4);
    check("R10 lower on", lo_en, 1);
    begin
      int k = 0;
      while (lo_en && k < 200) begin k++; step(1); end
      check("R10 minimum on cycles", k, MINC + 1);
    end
    check("R9 cut state", seq_state, 6);
    step(8);
    check("R9 lower stays off", lo_en, 0);
    ccm_force = 1'b1;
    step(1);
    check("R11 not yet on", lo_en, 0);
    step(1);
    check("R11 lower restored by ccm", lo_en, 1);
    ccm_force = 1'b0;
    step(MINC + 2);
    check("R9 cut again", lo_en, 0);
    zero_cross = 1'b0; lo_gate_dis = 1'b1; pwm_code = 2'b01;
    step(4);
    check("R9 next high period upper on", hi_en, 1);
    ccm_force = 1'b1;
  endtask

  task automatic t_supply_R12();
    go_hi_on();
    supply_ok = 1'b0;
    step(1);
    check("R12 supply drop hi_en", hi_en, 0);
    check("R12 supply drop state", seq_state, 0);
    pwm_code = 2'b00;
    step(8);
    check("R12 held idle lo_en", lo_en, 0);
    supply_ok = 1'b1;
    step(4);
    check("R12 resume lower", lo_en, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rise_R1();
    t_fall_R2();
    t_shut_R4_R6(2'b10, "R4");
    t_shut_R4_R6(2'b11, "R5");
    t_restart_R7();
    t_ccm_R8();
    t_dcm_R9_R10_R11();
    t_supply_R12();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule